// File: doc/BRIEF.md
# Cascadable Byte-Scan Readout Controller

This block puts a wide held data word onto a narrow shared bus one byte at a time. The least significant byte comes first. A host steps through the bytes with a scan strobe. Each high phase of the strobe asks for one byte. The block drives the bus only during that high phase, so the host is free to use the bus while the strobe is low.

After the last byte has been taken, the block enters a terminal state. In that state the bus stays blanked and the active-low chain output falls and holds. Wiring the chain output of one unit to the active-low enable of the next, with all units sharing the strobe and the scan-reset, makes the units hand the bus from one to the next. A low pulse on scan-reset starts a new pass.

Top module: `byte_scan_rdout`

## Requirements
- R1: After `rst_n` or `scan_rst_n` is low for one clock edge, the selection is byte 0 (bits BYTE_W-1:0) and `chain_n` is high.
- R2: With `en_n` low, the scan falling edge is seen at the first clock edge at which `scan` is sampled low after being sampled high. At that edge the selection moves to the next more significant byte.
- R3: After NUM_BYTES falling edges the block is in the terminal state and `chain_n` is low. Further falling edges leave it there until `scan_rst_n` is low.
- R4: `bus_oe` is high exactly when all four of these hold: `scan` is high, `en_n` is low, `scan_rst_n` is high, and the block is not in the terminal state.
- R5: While `bus_oe` is high, `bus_byte` equals the selected byte of `word`. While `bus_oe` is low, `bus_byte` is zero.
- R6: While `en_n` is high, scan falling edges do not move the selection.
- R7: When `scan_rst_n` is low at the same clock edge as a scan falling edge, the selection becomes byte 0.
- R8: The selection does not change across consecutive cycles in which `bus_oe` is high.
- R9: Two units chained (the first unit's `chain_n` driving the second unit's `en_n`) place all 2×NUM_BYTES bytes on the bus in order. They never drive it at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scan | input | 1 | Synchronized scan strobe |
| en_n | input | 1 | Active-low unit enable |
| scan_rst_n | input | 1 | Active-low return to byte 0 |
| word | input | WORD_W | Held data word to read out |
| bus_byte | output | BYTE_W | Selected byte, zero while not driving |
| bus_oe | output | 1 | Bus drive enable for the pad drivers |
| chain_n | output | 1 | Low once all bytes have been presented |

## Verification
The bench builds two units with the default 32-bit word and 8-bit byte, which gives a four-byte pass and a terminal state at encoding 5. Chaining the two units brings the handoff into reach: the second unit's enable follows the first unit's chain output, and the bench reads an eight-byte sequence from a merged bus. With the default zero-idle variant, the blanked bus value is zero and can be checked directly.

// File: rtl/byte_scan_pkg.sv
package byte_scan_pkg;

   // Falling edge of a sampled strobe: previous sample high, present sample low.
   function automatic logic strobe_fell(input logic prev_s, input logic cur_s);
      return prev_s & ~cur_s;
   endfunction

   // Width needed for the scan state: values 0..num_bytes+1, where 0 is illegal.
   function automatic int state_width(input int num_bytes);
      int w;
      w = 1;
      while ((1 << w) < (num_bytes + 2)) w++;
      return w;
   endfunction

endpackage

// File: rtl/scan_edge_det.sv
module scan_edge_det
   import byte_scan_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic scan_in,
   output logic fall_o
);

   logic scan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scan_q <= 1'b0;
      else        scan_q <= scan_in;
   end

   assign fall_o = strobe_fell(scan_q, scan_in);

endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
   parameter int NUM_BYTES = 4,
   parameter int SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_rst_n,
   input  logic             en_n,
   input  logic             fall,
   output logic [SEL_W-1:0] state_o,
   output logic             done_o
);

   localparam logic [SEL_W-1:0] FIRST_ST = SEL_W'(1);
   localparam logic [SEL_W-1:0] DONE_ST  = SEL_W'(NUM_BYTES + 1);

   logic [SEL_W-1:0] state;
   logic             illegal;

   assign illegal = (state == '0) || (state > DONE_ST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   state <= FIRST_ST;
      else if (!scan_rst_n)                         state <= FIRST_ST;
      else if (illegal)                             state <= FIRST_ST;
      else if (!en_n && fall && state != DONE_ST)   state <= state + SEL_W'(1);
   end

   assign state_o = state;
   assign done_o  = (state == DONE_ST);

endmodule

// File: rtl/byte_sel_mux.sv
module byte_sel_mux #(
   parameter int WORD_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SEL_W-1:0]  state,
   input  logic              oe,
   output logic [BYTE_W-1:0] byte_o
);

   localparam int NUM_BYTES = WORD_W / BYTE_W;

   logic [BYTE_W-1:0] lanes [NUM_BYTES];
   logic [BYTE_W-1:0] pick;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      assign lanes[g] = word[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      pick = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (state == SEL_W'(i + 1)) pick = lanes[i];
      end
   end

   if (IDLE_ZERO) begin : g_idle_zero
      assign byte_o = oe ? pick : '0;
   end else begin : g_idle_pass
      assign byte_o = pick;
   end

endmodule

// File: rtl/byte_scan_rdout.sv
module byte_scan_rdout
   import byte_scan_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan,
   input  logic              en_n,
   input  logic              scan_rst_n,
   input  logic [WORD_W-1:0] word,
   output logic [BYTE_W-1:0] bus_byte,
   output logic              bus_oe,
   output logic              chain_n
);

   localparam int NUM_BYTES = WORD_W / BYTE_W;
   localparam int SEL_W     = state_width(NUM_BYTES);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("byte_scan_rdout: BYTE_W must be at least 1");
   end
   if (WORD_W % BYTE_W != 0) begin : g_bad_ratio
      $error("byte_scan_rdout: WORD_W must be a multiple of BYTE_W");
   end
   if (NUM_BYTES < 1) begin : g_bad_count
      $error("byte_scan_rdout: at least one byte is required");
   end

   logic             fall;
   logic [SEL_W-1:0] cur_state;
   logic             done;

   scan_edge_det u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_in (scan),
      .fall_o  (fall)
   );

   scan_seq #(
      .NUM_BYTES (NUM_BYTES),
      .SEL_W     (SEL_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_rst_n (scan_rst_n),
      .en_n       (en_n),
      .fall       (fall),
      .state_o    (cur_state),
      .done_o     (done)
   );

   assign bus_oe  = scan & ~en_n & scan_rst_n & ~done;
   assign chain_n = ~done;

   byte_sel_mux #(
      .WORD_W    (WORD_W),
      .BYTE_W    (BYTE_W),
      .SEL_W     (SEL_W),
      .IDLE_ZERO (IDLE_ZERO)
   ) u_mux (
      .word   (word),
      .state  (cur_state),
      .oe     (bus_oe),
      .byte_o (bus_byte)
   );

endmodule

// File: rtl/byte_scan_rdout_chk.sv
module byte_scan_rdout_chk #(
   parameter int NUM_BYTES = 4,
   parameter int SEL_W     = 3,
   parameter int BYTE_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scan,
   input logic             en_n,
   input logic             scan_rst_n,
   input logic             fall,
   input logic [SEL_W-1:0] state,
   input logic [BYTE_W-1:0] bus_byte,
   input logic             bus_oe,
   input logic             chain_n
);

   localparam logic [SEL_W-1:0] DONE_ST = SEL_W'(NUM_BYTES + 1);

   assert_scan_rst_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_rst_n |=> (state == SEL_W'(1)) && chain_n);

   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_rst_n && !en_n && fall && state != DONE_ST && state != '0)
         |=> state == $past(state) + SEL_W'(1));

   assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_n && scan_rst_n) |=> !chain_n);

   assert_oe_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (scan && !en_n && scan_rst_n && chain_n));

   assert_idle_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (IDLE_ZERO && !bus_oe) |-> bus_byte == '0);

   assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n && scan_rst_n && state != '0 && state <= DONE_ST) |=> $stable(state));

   assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_rst_n && fall) |=> state == SEL_W'(1));

   assert_sel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe)) |-> $stable(state));

   assert_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (state != '0) && (state <= DONE_ST));

endmodule

bind byte_scan_rdout byte_scan_rdout_chk #(
   .NUM_BYTES (NUM_BYTES),
   .SEL_W     (SEL_W),
   .BYTE_W    (BYTE_W),
   .IDLE_ZERO (IDLE_ZERO)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scan       (scan),
   .en_n       (en_n),
   .scan_rst_n (scan_rst_n),
   .fall       (fall),
   .state      (cur_state),
   .bus_byte   (bus_byte),
   .bus_oe     (bus_oe),
   .chain_n    (chain_n)
);

// File: tb/tb_byte_scan_rdout.sv
module tb_byte_scan_rdout;

   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;
   localparam int NB     = WORD_W / BYTE_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scan = 1'b0;
   logic en_n = 1'b0;
   logic scan_rst_n = 1'b1;
   logic [WORD_W-1:0] word_a = 32'hA1B2_C3D4;
   logic [WORD_W-1:0] word_b = 32'h1526_3748;

   logic [BYTE_W-1:0] byte_a, byte_b, bus;
   logic oe_a, oe_b, chain_a, chain_b;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   byte_scan_rdout #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) dut (
      .clk(clk), .rst_n(rst_n), .scan(scan), .en_n(en_n), .scan_rst_n(scan_rst_n),
      .word(word_a), .bus_byte(byte_a), .bus_oe(oe_a), .chain_n(chain_a)
   );

   byte_scan_rdout #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) dut_next (
      .clk(clk), .rst_n(rst_n), .scan(scan), .en_n(chain_a), .scan_rst_n(scan_rst_n),
      .word(word_b), .bus_byte(byte_b), .bus_oe(oe_b), .chain_n(chain_b)
   );

   assign bus = oe_a ? byte_a : (oe_b ? byte_b : '0);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [BYTE_W-1:0] lane(input logic [WORD_W-1:0] w, input int i);
      return w[i*BYTE_W +: BYTE_W];
   endfunction

   // Raise scan, sample the driven byte, drop scan, sample the blank bus, let the edge register.
   task automatic pulse(output logic oe_hi, output logic [BYTE_W-1:0] b_hi,
                        output logic oe_lo, output logic [BYTE_W-1:0] b_lo);
      @(negedge clk); scan = 1'b1; #1;
      oe_hi = oe_a | oe_b; b_hi = bus;
      @(negedge clk); scan = 1'b0; #1;
      oe_lo = oe_a | oe_b; b_lo = bus;
      @(negedge clk);
   endtask

   task automatic scan_restart();
      @(negedge clk); scan_rst_n = 1'b0;
      @(negedge clk); scan_rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      #1;
      chk(chain_a === 1'b1, "R1 chain after reset", 32'(chain_a), 1);
      chk(oe_a === 1'b0, "R4 oe with scan low", 32'(oe_a), 0);
      chk(byte_a === '0, "R5 blank byte", 32'(byte_a), 0);
   endtask

   task automatic t_single_pass();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      scan_restart();
      for (int i = 0; i < NB; i++) begin
         pulse(oh, bh, ol, bl);
         chk(oh === 1'b1, "R4 oe while scan high", 32'(oh), 1);
         chk(bh === lane(word_a, i), "R2 R5 byte order", 32'(bh), 32'(lane(word_a, i)));
         chk(ol === 1'b0 && bl === '0, "R5 blank while scan low", {ol, 8'(bl)}, 0);
      end
      chk(chain_a === 1'b0, "R3 chain low after last byte", 32'(chain_a), 0);
   endtask

   task automatic t_done_sticky();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      en_n = 1'b0;
      // Keep dut_next quiet: this test only looks at dut, so restart and run dut to done first.
      scan_restart();
      for (int i = 0; i < NB; i++) pulse(oh, bh, ol, bl);
      @(negedge clk); scan = 1'b1; #1;
      chk(oe_a === 1'b0, "R3 R4 no drive in terminal state", 32'(oe_a), 0);
      @(negedge clk); scan = 1'b0;
      @(negedge clk); #1;
      chk(chain_a === 1'b0, "R3 chain stays low", 32'(chain_a), 0);
      scan_restart(); #1;
      chk(chain_a === 1'b1, "R1 chain high after scan reset", 32'(chain_a), 1);
   endtask

   task automatic t_enable_hold();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      scan_restart();
      en_n = 1'b1;
      pulse(oh, bh, ol, bl);
      chk(!oe_a, "R4 no drive while disabled", 32'(oe_a), 0);
      pulse(oh, bh, ol, bl);
      en_n = 1'b0;
      @(negedge clk); scan = 1'b1; #1;
      chk(byte_a === lane(word_a, 0), "R6 disabled edges ignored", 32'(byte_a), 32'(lane(word_a, 0)));
      @(negedge clk); scan = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_priority();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      scan_restart();
      pulse(oh, bh, ol, bl);
      @(negedge clk); scan = 1'b1;
      @(negedge clk); scan = 1'b0; scan_rst_n = 1'b0;
      @(negedge clk); scan_rst_n = 1'b1; scan = 1'b1; #1;
      chk(byte_a === lane(word_a, 0), "R7 scan reset beats falling edge", 32'(byte_a), 32'(lane(word_a, 0)));
      @(negedge clk); scan = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_mid_restart_and_hold();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      scan_restart();
      pulse(oh, bh, ol, bl);
      pulse(oh, bh, ol, bl);
      @(negedge clk); scan = 1'b1;
      for (int k = 0; k < 5; k++) begin
         #1;
         chk(oe_a && byte_a === lane(word_a, 2), "R8 byte held while driving", 32'(byte_a), 32'(lane(word_a, 2)));
         @(negedge clk);
      end
      scan_rst_n = 1'b0; #1;
      chk(oe_a === 1'b0, "R4 no drive during scan reset", 32'(oe_a), 0);
      @(negedge clk); scan_rst_n = 1'b1; #1;
      chk(byte_a === lane(word_a, 0), "R1 mid-pass restart to byte 0", 32'(byte_a), 32'(lane(word_a, 0)));
      @(negedge clk); scan = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_chain();
      logic oh, ol; logic [BYTE_W-1:0] bh, bl;
      logic [BYTE_W-1:0] exp;
      scan_restart();
      for (int i = 0; i < 2*NB; i++) begin
         exp = (i < NB) ? lane(word_a, i) : lane(word_b, i - NB);
         @(negedge clk); scan = 1'b1; #1;
         chk(!(oe_a && oe_b), "R9 single driver", {oe_a, oe_b}, 0);
         chk((oe_a | oe_b) && bus === exp, "R9 chained byte order", 32'(bus), 32'(exp));
         @(negedge clk); scan = 1'b0;
         @(negedge clk);
      end
      pulse(oh, bh, ol, bl);
      chk(oh === 1'b0, "R9 bus idle after both units", 32'(oh), 0);
      chk(chain_b === 1'b0, "R9 second unit chain low", 32'(chain_b), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      t_single_pass();
      t_done_sticky();
      t_enable_hold();
      t_reset_priority();
      t_mid_restart_and_hold();
      t_chain();
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule